// File: doc/BRIEF.md
# Multimode Timer Channel with Prescaler

This block is one timer channel. It has a down counter of programmable width, eight bits by default, and a prescaler with a selectable divisor. Software drives the channel through two byte-wide registers on a simple write-strobe bus. One register holds the mode, and the other holds the reload value. The channel runs in one of three modes:

- **Delay mode.** The counter steps once per prescaler period.
- **Event-count mode.** The counter steps once per synchronized rising edge of an external input.
- **Pulse-width mode.** Prescaled counting runs only while the external input, used here as a gate, is active.

Each time the count runs out, the channel reloads the counter from the reload register, toggles a timeout output and sends a one-cycle event pulse to an interrupt controller. In pulse-width mode the channel also sends an event pulse when the gate goes inactive.

A parameter builds the channel as a delay-only variant. In that variant a write to the mode register cannot select the event-count or pulse-width codes. A reset stops the channel and drives both the timeout output and the event pulse low. Reset does not clear the counter or the reload value.

Top module: `mmt_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the mode register reads 0 (stopped), `tmo` is 0 and `irq_evt` is 0. Reset acts on `tmo` at once, without waiting for a clock edge.
- R2: The mode code is stored in mode register bits [3:0]. Codes 1 to 7 select delay mode with prescale divisors of 4, 10, 16, 50, 64, 100 and 200 in that order. A write to the mode register restarts the prescaler. With a reload value N, the first timeout toggle therefore comes exactly divisor × N cycles after the write, and later toggles follow at the same spacing.
- R3: When the counter runs out, it takes the reload value, `tmo` toggles and `irq_evt` is high for exactly one cycle. Reading the counter right after the toggle returns the reload value.
- R4: A reload value of 0 counts as 256 steps.
- R5: Code 8 selects event-count mode. The counter steps down by exactly one for each rising edge of the effective external input, after synchronization, and does not change otherwise.
- R6: Codes 9 to 15 select pulse-width mode, with the divisor chosen by bits [2:0] as in R2. Prescaled steps happen only while the effective input is high. One `irq_evt` pulse is produced when the effective input falls.
- R7: Mode register bit 4 inverts the external input before edge and level detection.
- R8: Register select 1 addresses the data register. A read there returns the live count. A write while the channel is stopped loads both the reload value and the counter. A write while the channel is running changes only the reload value, which takes effect at the next run-out.
- R9: While the mode is 0, the counter and `tmo` hold their values.
- R10: In the delay-only variant, a write to the mode register stores bit 3 as 0. A write of 9 therefore reads back as 1 and runs delay mode with divisor 4. A write of 8 reads back as 0, and the channel stays stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 for the mode register, 1 for the data register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| ext_in | input | 1 | External event input, or the gate in pulse-width mode |
| tmo | output | 1 | Timeout output; toggles at each run-out |
| irq_evt | output | 1 | One-cycle interrupt event pulse |

## Verification
The hardest check is the exact pulse-width count, because it depends on how the two-stage input synchronizer lines up with the prescaler phase. The bench holds the gate high for a known whole number of cycles, driven on falling clock edges. It then expects exactly that many cycles divided by the divisor in steps, plus a single trailing-edge event.

Polarity inversion also needs care, since flipping the polarity bit can create an edge nobody asked for. The bench therefore sets the input level before it changes the polarity, and only then pulses the input. A running-write check loads a new reload value partway through a long countdown. It confirms that the live count is untouched and that the next period uses the new value.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;

  localparam int BUS_W  = 8;
  localparam int MODE_W = 4;
  localparam int CTL_W  = MODE_W + 1;
  localparam int PRE_W  = 8;

  typedef enum logic [1:0] {
    CLS_STOP  = 2'd0,
    CLS_DELAY = 2'd1,
    CLS_EVENT = 2'd2,
    CLS_PULSE = 2'd3
  } mmt_cls_e;

  // Map a stored mode code onto its operating class.
  function automatic mmt_cls_e mode_class(input logic [MODE_W-1:0] m);
    mmt_cls_e c;
    if (m == '0)                    c = CLS_STOP;
    else if (!m[MODE_W-1])          c = CLS_DELAY;
    else if (m[MODE_W-2:0] == '0)   c = CLS_EVENT;
    else                            c = CLS_PULSE;
    return c;
  endfunction

  // Terminal value of the prescaler (divisor minus one) per select code.
  function automatic logic [PRE_W-1:0] pre_limit(input logic [MODE_W-2:0] sel);
    logic [PRE_W-1:0] l;
    case (sel)
      3'd1:    l = PRE_W'(3);
      3'd2:    l = PRE_W'(9);
      3'd3:    l = PRE_W'(15);
      3'd4:    l = PRE_W'(49);
      3'd5:    l = PRE_W'(63);
      3'd6:    l = PRE_W'(99);
      3'd7:    l = PRE_W'(199);
      default: l = PRE_W'(3);
    endcase
    return l;
  endfunction

endpackage

// File: rtl/mmt_insync.sv
`timescale 1ns/1ps
module mmt_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic inv,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin ^ inv};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

endmodule

// File: rtl/mmt_prescaler.sv
`timescale 1ns/1ps
module mmt_prescaler
  import mmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [MODE_W-2:0] sel,
  output logic              tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] lim;
  logic             at_lim;
  logic             pre_en;

  always_comb begin
    lim    = pre_limit(sel);
    at_lim = (pre_q == lim);
    tick   = run & ~clr & at_lim;
    pre_en = clr | run | (pre_q != '0);
    if (clr || !run || at_lim) pre_d = '0;
    else                       pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

endmodule

// File: rtl/mmt_counter.sv
`timescale 1ns/1ps
module mmt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec,
  input  logic             wr_rel,
  input  logic             load_now,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             tmo,
  output logic             hit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rel_q, rel_d;
  logic             cnt_en;
  logic             tmo_q, tmo_d;

  always_comb begin
    hit    = dec & ~load_now & (cnt_q == ONE);
    cnt_en = load_now | dec;
    rel_d  = wdata;
    if (load_now)  cnt_d = wdata;
    else if (hit)  cnt_d = rel_q;
    else           cnt_d = cnt_q - ONE;
    tmo_d  = hit ? ~tmo_q : tmo_q;
  end

  // Count and reload value are deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (cnt_en) cnt_q <= cnt_d;
    if (wr_rel) rel_q <= rel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_q <= 1'b0;
    else        tmo_q <= tmo_d;
  end

  assign cnt = cnt_q;
  assign tmo = tmo_q;

endmodule

// File: rtl/mmt_timer.sv
`timescale 1ns/1ps
module mmt_timer
  import mmt_pkg::*;
#(
  parameter bit FULL_MODES  = 1'b1,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             ext_in,
  output logic             tmo,
  output logic             irq_evt
);

  localparam int CTL_PAD = BUS_W - CTL_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic ctl_wr, dat_wr;
  assign ctl_wr = reg_wr & ~reg_sel;
  assign dat_wr = reg_wr &  reg_sel;

  // Mode register; the variant decides which codes can be stored.
  logic [MODE_W-1:0] mode_q, mode_d, mode_wr;
  logic              pol_q, pol_d;

  generate
    if (FULL_MODES) begin : g_full
      assign mode_wr = reg_wdata[MODE_W-1:0];
    end else begin : g_dly
      assign mode_wr = {1'b0, reg_wdata[MODE_W-2:0]};
    end
  endgenerate

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[BUS_W-1:CTL_W], reg_wdata[MODE_W-1]};

  always_comb begin
    mode_d = mode_wr;
    pol_d  = reg_wdata[MODE_W];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mode_q <= '0;
      pol_q  <= 1'b0;
    end else if (ctl_wr) begin
      mode_q <= mode_d;
      pol_q  <= pol_d;
    end
  end

  mmt_cls_e cls;
  assign cls = mode_class(mode_q);

  // Input conditioning.
  logic gate_lvl, evt_rise, gate_fall;

  mmt_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .pin   (ext_in),
    .inv   (pol_q),
    .level (gate_lvl),
    .rise  (evt_rise),
    .fall  (gate_fall)
  );

  // Prescaler.
  logic pre_run, pre_tick;
  assign pre_run = (cls == CLS_DELAY) | ((cls == CLS_PULSE) & gate_lvl);

  mmt_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_s),
    .run   (pre_run),
    .clr   (ctl_wr),
    .sel   (mode_q[MODE_W-2:0]),
    .tick  (pre_tick)
  );

  // Down counter.
  logic             cnt_dec, cnt_load, cnt_hit;
  logic [CNT_W-1:0] cnt_val;

  always_comb begin
    case (cls)
      CLS_EVENT:           cnt_dec = evt_rise;
      CLS_DELAY,
      CLS_PULSE:           cnt_dec = pre_tick;
      default:             cnt_dec = 1'b0;
    endcase
    cnt_load = dat_wr & (cls == CLS_STOP);
  end

  mmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s),
    .dec      (cnt_dec),
    .wr_rel   (dat_wr),
    .load_now (cnt_load),
    .wdata    (reg_wdata[CNT_W-1:0]),
    .cnt      (cnt_val),
    .tmo      (tmo),
    .hit      (cnt_hit)
  );

  // Interrupt event pulse.
  logic irq_q, irq_d;
  assign irq_d = cnt_hit | ((cls == CLS_PULSE) & gate_fall);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
  assign irq_evt = irq_q;

  // Read mux.
  always_comb begin
    if (reg_sel) reg_rdata = BUS_W'(cnt_val);
    else         reg_rdata = {{CTL_PAD{1'b0}}, pol_q, mode_q};
  end

endmodule

// File: rtl/mmt_timer_chk.sv
`timescale 1ns/1ps
module mmt_timer_chk #(
  parameter bit FULL_MODES = 1'b1,
  parameter int CNT_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [3:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic             tmo,
  input logic             irq_evt,
  input logic             rise
);

  logic pw_mode;
  assign pw_mode = mode[3] & (mode[2:0] != 3'd0);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!tmo && !irq_evt && mode == 4'd0); // R1
    end
  end

  AST_TMO_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo != $past(tmo)) |-> irq_evt); // R3

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && !pw_mode) |=> !irq_evt); // R3

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0 && $past(mode) == 4'd0 && !$past(reg_wr)) |-> ($stable(cnt) && $stable(tmo))); // R9

  AST_EVT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd8 && $past(mode) == 4'd8 && !$past(reg_wr) && !$past(rise)) |-> $stable(cnt)); // R5

  AST_DLY_ONLY_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (FULL_MODES == 1'b0) |-> !mode[3]); // R10

endmodule

bind mmt_timer mmt_timer_chk #(.FULL_MODES(FULL_MODES), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_s),
  .reg_wr  (reg_wr),
  .mode    (mode_q),
  .cnt     (cnt_val),
  .tmo     (tmo),
  .irq_evt (irq_evt),
  .rise    (evt_rise)
);

// File: tb/mmt_timer_tb.sv
`timescale 1ns/1ps
module mmt_timer_tb;

  logic       clk;
  logic       rst_n;
  logic       wr_a, wr_b, sel, ext;
  logic [7:0] wdata, rd_a, rd_b;
  logic       tmo_a, tmo_b, irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  int irq_cnt_a = 0;
  int irq_cnt_b = 0;
  bit done = 0;

  mmt_timer #(.FULL_MODES(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_sel(sel), .reg_wdata(wdata),
    .reg_rdata(rd_a), .ext_in(ext), .tmo(tmo_a), .irq_evt(irq_a)
  );

  mmt_timer #(.FULL_MODES(1'b0)) u_dly (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_sel(sel), .reg_wdata(wdata),
    .reg_rdata(rd_b), .ext_in(ext), .tmo(tmo_b), .irq_evt(irq_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (irq_a) irq_cnt_a++;
    if (irq_b) irq_cnt_b++;
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic bus_wr(input bit to_b, input bit s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wdata = d;
    if (to_b) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic bus_rd(input bit from_b, input bit s, output int v);
    sel = s;
    #1;
    v = from_b ? int'(rd_b) : int'(rd_a);
  endtask

  task automatic wait_toggle(input bit on_b, input int limit, output int n, output bit irq_seen);
    bit start;
    start = on_b ? tmo_b : tmo_a;
    n = 0; irq_seen = 1'b0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if ((on_b ? tmo_b : tmo_a) != start) begin
        irq_seen = on_b ? irq_b : irq_a;
        break;
      end
    end
  endtask

  task automatic evt_pulse(input bit active);
    @(negedge clk); ext = active;
    repeat (3) @(negedge clk);
    ext = ~active;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_delay(input bit on_b, input logic [7:0] code, input logic [7:0] n);
    bus_wr(on_b, 1'b0, 8'h00);
    bus_wr(on_b, 1'b1, n);
    bus_wr(on_b, 1'b0, code);
  endtask

  task automatic t_reset_state;
    int v;
    bus_rd(1'b0, 1'b0, v);
    check(v == 0, "R1 mode after reset", v, 0);
    check(tmo_a == 0 && irq_a == 0, "R1 outputs after reset", {tmo_a, irq_a}, 0);
  endtask

  task automatic t_delay_basic;
    int n, v, c0; bit irq;
    start_delay(1'b0, 8'h01, 8'd3);
    wait_toggle(1'b0, 500, n, irq);
    check(n == 12, "R2 first period div4 N3", n, 12);
    check(irq, "R3 irq at toggle", irq, 1);
    bus_rd(1'b0, 1'b1, v);
    check(v == 3, "R3 reload after run-out", v, 3);
    c0 = irq_cnt_a;
    wait_toggle(1'b0, 500, n, irq);
    #2;
    check(n == 12, "R2 steady period", n, 12);
    check(irq_cnt_a - c0 == 1, "R3 one-cycle irq", irq_cnt_a - c0, 1);
  endtask

  task automatic t_divisors;
    int dv[8] = '{0, 4, 10, 16, 50, 64, 100, 200};
    int n; bit irq;
    for (int s = 1; s < 8; s++) begin
      start_delay(1'b0, 8'(s), 8'd2);
      wait_toggle(1'b0, 1000, n, irq);
      check(n == 2 * dv[s], "R2 divisor period", n, 2 * dv[s]);
    end
  endtask

  task automatic t_zero_full;
    int n; bit irq;
    start_delay(1'b0, 8'h01, 8'd0);
    wait_toggle(1'b0, 2000, n, irq);
    check(n == 1024, "R4 zero reload is 256", n, 1024);
  endtask

  task automatic t_stop_and_load;
    int v1, v2; bit t0;
    start_delay(1'b0, 8'h01, 8'd200);
    repeat (30) @(negedge clk);
    bus_wr(1'b0, 1'b0, 8'h00);
    bus_rd(1'b0, 1'b1, v1);
    t0 = tmo_a;
    repeat (40) @(negedge clk);
    bus_rd(1'b0, 1'b1, v2);
    check(v1 == v2 && v1 < 200, "R9 stopped counter frozen", v2, v1);
    check(tmo_a == t0, "R9 stopped tmo frozen", tmo_a, t0);
    bus_wr(1'b0, 1'b1, 8'd77);
    bus_rd(1'b0, 1'b1, v1);
    check(v1 == 77, "R8 stopped write loads counter", v1, 77);
  endtask

  task automatic t_running_write;
    int v, n; bit irq;
    start_delay(1'b0, 8'h01, 8'd50);
    repeat (20) @(negedge clk);
    bus_wr(1'b0, 1'b1, 8'd2);
    bus_rd(1'b0, 1'b1, v);
    check(v >= 40 && v <= 50, "R8 running write keeps count", v, 45);
    wait_toggle(1'b0, 400, n, irq);
    wait_toggle(1'b0, 400, n, irq);
    check(n == 8, "R8 new reload next period", n, 8);
  endtask

  task automatic t_event;
    int v, c0; bit t0;
    ext = 1'b0;
    bus_wr(1'b0, 1'b0, 8'h00);
    bus_wr(1'b0, 1'b1, 8'd4);
    bus_wr(1'b0, 1'b0, 8'h08);
    repeat (4) @(negedge clk);
    evt_pulse(1'b1); evt_pulse(1'b1);
    bus_rd(1'b0, 1'b1, v);
    check(v == 2, "R5 one step per edge", v, 2);
    t0 = tmo_a; c0 = irq_cnt_a;
    evt_pulse(1'b1); evt_pulse(1'b1);
    #2;
    bus_rd(1'b0, 1'b1, v);
    check(v == 4, "R5 reload in event mode", v, 4);
    check(tmo_a != t0, "R5 tmo toggles on run-out", tmo_a, !t0);
    check(irq_cnt_a - c0 == 1, "R5 irq on run-out", irq_cnt_a - c0, 1);
  endtask

  task automatic t_polarity;
    int v;
    bus_wr(1'b0, 1'b0, 8'h00);
    bus_wr(1'b0, 1'b1, 8'd3);
    ext = 1'b1;
    repeat (4) @(negedge clk);
    bus_wr(1'b0, 1'b0, 8'h18);
    repeat (4) @(negedge clk);
    bus_rd(1'b0, 1'b1, v);
    check(v == 3, "R7 no step on polarity change", v, 3);
    evt_pulse(1'b0);
    bus_rd(1'b0, 1'b1, v);
    check(v == 2, "R7 inverted input counts falling pin", v, 2);
    ext = 1'b0;
    bus_wr(1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_pulse;
    int v, c0;
    ext = 1'b0;
    bus_wr(1'b0, 1'b0, 8'h00);
    bus_wr(1'b0, 1'b1, 8'd100);
    bus_wr(1'b0, 1'b0, 8'h09);
    repeat (20) @(negedge clk);
    bus_rd(1'b0, 1'b1, v);
    check(v == 100, "R6 no count with gate low", v, 100);
    c0 = irq_cnt_a;
    @(negedge clk); ext = 1'b1;
    repeat (40) @(negedge clk);
    ext = 1'b0;
    repeat (6) @(negedge clk);
    #2;
    bus_rd(1'b0, 1'b1, v);
    check(v == 90, "R6 ten steps in 40 gated cycles", v, 90);
    check(irq_cnt_a - c0 == 1, "R6 irq at gate trailing edge", irq_cnt_a - c0, 1);
  endtask

  task automatic t_delay_only;
    int v, n; bit irq;
    bus_wr(1'b1, 1'b0, 8'h09);
    bus_rd(1'b1, 1'b0, v);
    check(v == 1, "R10 bit3 dropped", v, 1);
    start_delay(1'b1, 8'h09, 8'd2);
    wait_toggle(1'b1, 200, n, irq);
    check(n == 8, "R10 runs delay div4", n, 8);
    bus_wr(1'b1, 1'b0, 8'h08);
    bus_rd(1'b1, 1'b0, v);
    check(v == 0, "R10 event code becomes stop", v, 0);
    bus_wr(1'b1, 1'b1, 8'd5);
    evt_pulse(1'b1); evt_pulse(1'b1);
    bus_rd(1'b1, 1'b1, v);
    check(v == 5, "R10 edges ignored", v, 5);
  endtask

  task automatic t_reset_mid;
    int v, guard;
    start_delay(1'b0, 8'h01, 8'd1);
    guard = 0;
    while (tmo_a != 1'b1 && guard < 100) begin
      @(negedge clk); guard++;
    end
    check(tmo_a == 1'b1, "R1 tmo high before reset", tmo_a, 1);
    #1 rst_n = 1'b0;
    #1;
    check(tmo_a == 1'b0, "R1 reset clears tmo at once", tmo_a, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(1'b0, 1'b0, v);
    check(v == 0, "R1 mode stopped after reset", v, 0);
    repeat (20) @(negedge clk);
    check(tmo_a == 1'b0 && irq_a == 1'b0, "R1 idle after reset", {tmo_a, irq_a}, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_a = 1'b0; wr_b = 1'b0; sel = 1'b0; wdata = 8'h00; ext = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_delay_basic();
    t_divisors();
    t_zero_full();
    t_stop_and_load();
    t_running_write();
    t_event();
    t_polarity();
    t_pulse();
    t_delay_only();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog got %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule